// File: doc/BRIEF.md
# Nibble-Register BCD Real-Time Clock

This block keeps calendar time as thirteen separately addressed 4-bit BCD digit registers. It sits behind a small register bus: a 4-bit address, 4-bit write and read data, and one-cycle write and read strobes. It counts seconds, minutes, hours, day of month, month, a two-digit year and the day of week. The time base comes from two one-cycle enables, a 1 Hz tick and a 64 Hz tick, which are generated elsewhere.

Three control nibbles sit above the time digits. Control D carries the host's hold request, the busy indication, the periodic-event flag and a request to round the seconds to the nearest minute. Control E picks the period of the event flag, chooses a latched flag or a short pulse, and masks the output pin. Control F picks 12-hour or 24-hour counting, can stop the clock, and can hold the seconds at zero. To read or set the time consistently, the host raises hold, reads or writes the digits, and then drops hold. A second that arrives while hold is up is applied after hold is dropped.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the digits read as year 00, month 01, day 01, 00:00:00, day of week 0. Control D reads 0000, control E reads 0001 (masked), and control F reads 0100 (24-hour). Addresses 0x0 to 0xB hold seconds, minutes, hours, day, month and year as units then tens. Address 0xC holds the day of week, and 0xD to 0xF hold controls D, E and F.
- R2: Each counting step adds one second in BCD. Seconds 59 become 00 and carry into the minutes, and minutes 59 become 00 and carry into the hours.
- R3: While hold (D bit 0) is 1, the digits do not count. A 1 Hz tick seen during hold is kept, and it is applied exactly once after hold returns to 0, however many ticks arrived during hold.
- R4: With F bit 2 = 1 (24-hour mode), 23:59:59 rolls to 00:00:00 and carries into the day.
- R5: With F bit 2 = 0 (12-hour mode), the hours run 12, 1, ..., 11. Bit 2 of the hours-tens nibble is the PM flag and bits 1:0 are the tens digit. 11:59:59 rolls to 12:00:00 with PM toggled. 12:59:59 rolls to 01:00:00. Only the 11 PM to 12 AM roll carries into the day.
- R6: At the last day of the month the day returns to 01 and the month advances. Months 4, 6, 9 and 11 have 30 days, and February has 29 days when the year value is a multiple of 4, otherwise 28. Month 12 rolls to 01 and carries into the year, the year 99 rolls to 00, and the day of week rolls 6 to 0 on every day carry.
- R7: Control D bit 1 (busy) reads 1 when the read strobe falls in the cycle in which a counting step occurs, and 0 otherwise.
- R8: Writing D with bit 3 = 1 requests a round to the minute. Once hold is 0, seconds of 30 or more become 00 with one minute carried, and seconds below 30 become 00. The bit then reads 0 again.
- R9: F bit 1 (stop) freezes counting and discards ticks, including one that was kept during hold. F bit 0 forces the seconds to 00 and blocks counting.
- R10: Control E bits 3:2 pick the event source: 00 = each 64 Hz tick, 01 = each second step, 10 = each minute carry, 11 = each hour carry. With E bit 1 = 1 the event flag (D bit 2) stays set until D is written with bit 2 = 0. `irq_out` is the flag gated by E bit 0 = 0.
- R11: With E bit 1 = 0 the flag is a pulse: it is cleared by the first 64 Hz tick that is not itself an event.
- R12: `rdata` shows the register at `addr` one cycle after `rd_en`, and keeps that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle 1 Hz time-base enable |
| tick_64hz | input | 1 | One-cycle 64 Hz time-base enable |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data nibble |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 4 | Registered read data |
| irq_out | output | 1 | Periodic event output |

## Verification
A wrong carry shows up at the digit registers on the read that follows the step: the wrong digit or a missing rollover into the next field is seen within one cycle of the tick. Faults in the 12-hour and leap-year rules appear only at their exact boundary times, so each such rollover is set up with hold and then stepped once. A lost or doubled pending tick is visible as a seconds value off by one after hold is released. A wrong flag state reaches `irq_out` at the first sampling point after the event or after the clearing write.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
   localparam int unsigned NIB_W      = 4;
   localparam int unsigned TIME_REGS  = 13;

   localparam logic [3:0] ADR_SEC_U  = 4'h0;
   localparam logic [3:0] ADR_SEC_T  = 4'h1;
   localparam logic [3:0] ADR_MIN_U  = 4'h2;
   localparam logic [3:0] ADR_MIN_T  = 4'h3;
   localparam logic [3:0] ADR_HR_U   = 4'h4;
   localparam logic [3:0] ADR_HR_T   = 4'h5;
   localparam logic [3:0] ADR_DAY_U  = 4'h6;
   localparam logic [3:0] ADR_DAY_T  = 4'h7;
   localparam logic [3:0] ADR_MON_U  = 4'h8;
   localparam logic [3:0] ADR_MON_T  = 4'h9;
   localparam logic [3:0] ADR_YR_U   = 4'hA;
   localparam logic [3:0] ADR_YR_T   = 4'hB;
   localparam logic [3:0] ADR_WEEK   = 4'hC;
   localparam logic [3:0] ADR_CTL_D  = 4'hD;
   localparam logic [3:0] ADR_CTL_E  = 4'hE;
   localparam logic [3:0] ADR_CTL_F  = 4'hF;

   localparam logic [1:0] PER_TICK64 = 2'd0;
   localparam logic [1:0] PER_SECOND = 2'd1;
   localparam logic [1:0] PER_MINUTE = 2'd2;
   localparam logic [1:0] PER_HOUR   = 2'd3;

   typedef logic [TIME_REGS-1:0][NIB_W-1:0] digit_bank_t;

   function automatic logic [6:0] bcd2bin(input logic [3:0] tens, input logic [3:0] units);
      return 7'(tens) * 7'd10 + 7'(units);
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [6:0] month_len(input logic [6:0] month, input logic leap);
      case (month)
         7'd2:                     return leap ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
         default:                  return 7'd31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
   import rtc_pkg::*;
#(
   parameter int unsigned LEAP_RULE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              adjust_i,
   input  logic              clr_sec_i,
   input  logic              mode24_i,
   input  logic              wr_i,
   input  logic [3:0]        waddr_i,
   input  logic [NIB_W-1:0]  wdata_i,
   output digit_bank_t       digits_o,
   output logic              min_evt_o,
   output logic              hour_evt_o
);
   if (LEAP_RULE > 1) begin : g_bad_leap
      $error("rtc_time_chain: LEAP_RULE must be 0 or 1");
   end

   digit_bank_t q, nxt;
   logic c_min, c_hour, c_day, c_mon, c_year;
   logic leap;
   logic [6:0] yr_bin, day_bin, mon_bin, dim;
   logic [7:0] hr_inc;
   logic       pm;
   logic       plain_step;

   assign yr_bin  = bcd2bin(q[ADR_YR_T],  q[ADR_YR_U]);
   assign day_bin = bcd2bin(q[ADR_DAY_T], q[ADR_DAY_U]);
   assign mon_bin = bcd2bin(q[ADR_MON_T], q[ADR_MON_U]);

   if (LEAP_RULE == 1) begin : g_leap_every4
      assign leap = (yr_bin[1:0] == 2'b00);
   end else begin : g_leap_never
      assign leap = 1'b0;
   end

   assign dim        = month_len(mon_bin, leap);
   assign pm         = q[ADR_HR_T][2];
   assign hr_inc     = bcd_inc({2'b00, q[ADR_HR_T][1:0], q[ADR_HR_U]});
   assign plain_step = step_i & ~adjust_i & ~clr_sec_i;

   always_comb begin
      nxt    = q;
      c_min  = 1'b0;
      c_hour = 1'b0;
      c_day  = 1'b0;
      c_mon  = 1'b0;
      c_year = 1'b0;

      // seconds: clear, round, or count
      if (clr_sec_i) begin
         nxt[ADR_SEC_U] = 4'd0;
         nxt[ADR_SEC_T] = 4'd0;
      end else if (adjust_i) begin
         nxt[ADR_SEC_U] = 4'd0;
         nxt[ADR_SEC_T] = 4'd0;
         c_min          = (q[ADR_SEC_T] >= 4'd3);
      end else if (step_i) begin
         if ({q[ADR_SEC_T], q[ADR_SEC_U]} >= 8'h59) begin
            nxt[ADR_SEC_U] = 4'd0;
            nxt[ADR_SEC_T] = 4'd0;
            c_min          = 1'b1;
         end else begin
            {nxt[ADR_SEC_T], nxt[ADR_SEC_U]} = bcd_inc({q[ADR_SEC_T], q[ADR_SEC_U]});
         end
      end

      // minutes
      if (c_min) begin
         if ({q[ADR_MIN_T], q[ADR_MIN_U]} >= 8'h59) begin
            nxt[ADR_MIN_U] = 4'd0;
            nxt[ADR_MIN_T] = 4'd0;
            c_hour         = 1'b1;
         end else begin
            {nxt[ADR_MIN_T], nxt[ADR_MIN_U]} = bcd_inc({q[ADR_MIN_T], q[ADR_MIN_U]});
         end
      end

      // hours, 24-hour or 12-hour with PM flag in bit 2 of the tens nibble
      if (c_hour) begin
         if (mode24_i) begin
            if ({q[ADR_HR_T][1:0], q[ADR_HR_U]} >= 6'h23) begin
               nxt[ADR_HR_T] = 4'd0;
               nxt[ADR_HR_U] = 4'd0;
               c_day         = 1'b1;
            end else begin
               nxt[ADR_HR_T] = hr_inc[7:4];
               nxt[ADR_HR_U] = hr_inc[3:0];
            end
         end else begin
            if ({q[ADR_HR_T][1:0], q[ADR_HR_U]} == 6'h12) begin
               nxt[ADR_HR_T] = {1'b0, pm, 2'b00};
               nxt[ADR_HR_U] = 4'd1;
            end else if ({q[ADR_HR_T][1:0], q[ADR_HR_U]} == 6'h11) begin
               nxt[ADR_HR_T] = {1'b0, ~pm, 2'b01};
               nxt[ADR_HR_U] = 4'd2;
               c_day         = pm;
            end else begin
               nxt[ADR_HR_T] = hr_inc[7:4] | {1'b0, pm, 2'b00};
               nxt[ADR_HR_U] = hr_inc[3:0];
            end
         end
      end

      // day of month and day of week
      if (c_day) begin
         nxt[ADR_WEEK] = (q[ADR_WEEK] >= 4'd6) ? 4'd0 : q[ADR_WEEK] + 4'd1;
         if (day_bin >= dim) begin
            nxt[ADR_DAY_T] = 4'd0;
            nxt[ADR_DAY_U] = 4'd1;
            c_mon          = 1'b1;
         end else begin
            {nxt[ADR_DAY_T], nxt[ADR_DAY_U]} = bcd_inc({q[ADR_DAY_T], q[ADR_DAY_U]});
         end
      end

      // month
      if (c_mon) begin
         if (mon_bin >= 7'd12) begin
            nxt[ADR_MON_T] = 4'd0;
            nxt[ADR_MON_U] = 4'd1;
            c_year         = 1'b1;
         end else begin
            {nxt[ADR_MON_T], nxt[ADR_MON_U]} = bcd_inc({q[ADR_MON_T], q[ADR_MON_U]});
         end
      end

      // two-digit year
      if (c_year) begin
         if (yr_bin >= 7'd99) begin
            nxt[ADR_YR_T] = 4'd0;
            nxt[ADR_YR_U] = 4'd0;
         end else begin
            {nxt[ADR_YR_T], nxt[ADR_YR_U]} = bcd_inc({q[ADR_YR_T], q[ADR_YR_U]});
         end
      end

      // host write wins over counting for the addressed digit
      if (wr_i && (waddr_i < 4'(TIME_REGS))) nxt[waddr_i] = wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q            <= '0;
         q[ADR_DAY_U] <= 4'd1;
         q[ADR_MON_U] <= 4'd1;
      end else begin
         q <= nxt;
      end
   end

   assign digits_o   = q;
   assign min_evt_o  = plain_step & c_min;
   assign hour_evt_o = plain_step & c_hour;
endmodule

// File: rtl/rtc_period_gen.sv
`timescale 1ns/1ps
module rtc_period_gen
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick64_i,
   input  logic       sec_i,
   input  logic       min_i,
   input  logic       hour_i,
   input  logic [1:0] sel_i,
   input  logic       latch_mode_i,
   input  logic       clr_i,
   output logic       flag_o
);
   logic evt;

   always_comb begin
      case (sel_i)
         PER_TICK64: evt = tick64_i;
         PER_SECOND: evt = sec_i;
         PER_MINUTE: evt = min_i;
         PER_HOUR:   evt = hour_i;
         default:    evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_o <= 1'b0;
      else if (evt)                        flag_o <= 1'b1;
      else if (clr_i)                      flag_o <= 1'b0;
      else if (!latch_mode_i && tick64_i)  flag_o <= 1'b0;
   end
endmodule

// File: rtl/nibble_rtc.sv
`timescale 1ns/1ps
module nibble_rtc
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 4,
   parameter int unsigned LEAP_RULE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              tick_64hz,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_out
);
   if (ADDR_W != 4) begin : g_bad_addr
      $error("nibble_rtc: ADDR_W must be 4");
   end
   if (DATA_W != NIB_W) begin : g_bad_data
      $error("nibble_rtc: DATA_W must equal the nibble width");
   end

   localparam logic [3:0] CTL_E_RST = 4'b0001;
   localparam logic [3:0] CTL_F_RST = 4'b0100;

   logic        hold_q, adj_q, pend_q;
   logic [3:0]  ctl_e_q, ctl_f_q;
   logic [3:0]  rdata_q;
   logic        wr_d, wr_e, wr_f;
   logic        stop_c, zero_c, mode24_c;
   logic        adj_go, do_step;
   logic        irq_flag, flag_clr;
   logic        min_evt, hour_evt;
   digit_bank_t time_digits;
   logic [3:0]  rd_mux;

   assign wr_d     = wr_en && (addr == ADR_CTL_D);
   assign wr_e     = wr_en && (addr == ADR_CTL_E);
   assign wr_f     = wr_en && (addr == ADR_CTL_F);
   assign stop_c   = ctl_f_q[1];
   assign zero_c   = ctl_f_q[0];
   assign mode24_c = ctl_f_q[2];

   assign adj_go   = adj_q & ~hold_q & ~stop_c & ~zero_c;
   assign do_step  = (tick_1hz | pend_q) & ~hold_q & ~stop_c & ~zero_c & ~adj_go;
   assign flag_clr = wr_d & ~wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= 1'b0;
         adj_q   <= 1'b0;
         pend_q  <= 1'b0;
         ctl_e_q <= CTL_E_RST;
         ctl_f_q <= CTL_F_RST;
      end else begin
         if (wr_d) hold_q <= wdata[0];
         if (wr_d && wdata[3]) adj_q <= 1'b1;
         else if (adj_go)      adj_q <= 1'b0;
         if (stop_c || zero_c) pend_q <= 1'b0;
         else if (do_step)     pend_q <= 1'b0;
         else if (tick_1hz)    pend_q <= 1'b1;
         if (wr_e) ctl_e_q <= wdata;
         if (wr_f) ctl_f_q <= wdata;
      end
   end

   rtc_time_chain #(.LEAP_RULE(LEAP_RULE)) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (do_step),
      .adjust_i   (adj_go),
      .clr_sec_i  (zero_c),
      .mode24_i   (mode24_c),
      .wr_i       (wr_en),
      .waddr_i    (addr),
      .wdata_i    (wdata),
      .digits_o   (time_digits),
      .min_evt_o  (min_evt),
      .hour_evt_o (hour_evt)
   );

   rtc_period_gen u_period (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick64_i     (tick_64hz),
      .sec_i        (do_step),
      .min_i        (min_evt),
      .hour_i       (hour_evt),
      .sel_i        (ctl_e_q[3:2]),
      .latch_mode_i (ctl_e_q[1]),
      .clr_i        (flag_clr),
      .flag_o       (irq_flag)
   );

   always_comb begin
      if (addr < 4'(TIME_REGS))       rd_mux = time_digits[addr];
      else if (addr == ADR_CTL_D)     rd_mux = {adj_q, irq_flag, do_step, hold_q};
      else if (addr == ADR_CTL_E)     rd_mux = ctl_e_q;
      else                            rd_mux = ctl_f_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

   assign rdata   = rdata_q;
   assign irq_out = irq_flag & ~ctl_e_q[0];
endmodule

// File: rtl/nibble_rtc_checker.sv
`timescale 1ns/1ps
module nibble_rtc_checker
   import rtc_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        hold,
   input logic        adj,
   input logic        stop,
   input logic        zero,
   input logic        latch,
   input logic        flag,
   input logic        wr,
   input logic [3:0]  addr,
   input logic [3:0]  wdata,
   input digit_bank_t digits
);
   logic time_wr;
   assign time_wr = wr && (addr < 4'(TIME_REGS));

   p_hold_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !zero && !time_wr) |=> $stable(digits));

   p_stop_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !zero && !time_wr) |=> $stable(digits));

   p_zero_secs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !(wr && addr < 4'd2)) |=> (digits[0] == 4'd0 && digits[1] == 4'd0));

   p_adj_selfclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adj && !hold && !stop && !zero && !(wr && addr == ADR_CTL_D)) |=> !adj);

   p_flag_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && latch && !(wr && addr == ADR_CTL_D && !wdata[2])) |=> flag);

   p_week_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !time_wr |=> (digits[ADR_WEEK] <= 4'd6));

   p_sec_units_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !time_wr |=> (digits[ADR_SEC_U] <= 4'd9));
endmodule

bind nibble_rtc nibble_rtc_checker u_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .hold   (hold_q),
   .adj    (adj_q),
   .stop   (ctl_f_q[1]),
   .zero   (ctl_f_q[0]),
   .latch  (ctl_e_q[1]),
   .flag   (irq_flag),
   .wr     (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .digits (time_digits)
);

// File: tb/nibble_rtc_bench.sv
`timescale 1ns/1ps
module nibble_rtc_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       tick_64hz = 1'b0;
   logic [3:0] addr = '0;
   logic [3:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [3:0] rdata;
   logic       irq_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   nibble_rtc u_nibble_rtc (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_64hz(tick_64hz),
      .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
      .rdata(rdata), .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [3:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic tick1();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   task automatic tick64();
      @(negedge clk); tick_64hz = 1'b1;
      @(negedge clk); tick_64hz = 1'b0;
   endtask

   function automatic logic [47:0] tm(int yy, int mo, int dd, int htn, int hu, int mi, int ss);
      return {4'(yy/10), 4'(yy%10), 4'(mo/10), 4'(mo%10), 4'(dd/10), 4'(dd%10),
              4'(htn), 4'(hu), 4'(mi/10), 4'(mi%10), 4'(ss/10), 4'(ss%10)};
   endfunction

   task automatic set_time(input int yy, input int mo, input int dd, input int htn,
                           input int hu, input int mi, input int ss, input int wk);
      logic [47:0] v;
      v = tm(yy, mo, dd, htn, hu, mi, ss);
      wr_reg(4'hD, 4'b0001);
      for (int i = 0; i < 12; i++) wr_reg(4'(i), v[i*4 +: 4]);
      wr_reg(4'hC, 4'(wk));
      wr_reg(4'hD, 4'b0000);
   endtask

   task automatic read_time(output logic [47:0] t);
      logic [3:0] v;
      t = '0;
      for (int i = 11; i >= 0; i--) begin
         rd_reg(4'(i), v);
         t = {t[43:0], v};
      end
   endtask

   task automatic t_reset();
      logic [47:0] t; logic [3:0] v;
      read_time(t);
      check("R1 reset time", t, tm(0, 1, 1, 0, 0, 0, 0));
      rd_reg(4'hC, v); check("R1 reset week", v, 0);
      rd_reg(4'hD, v); check("R1 reset ctl D", v, 4'b0000);
      rd_reg(4'hE, v); check("R1 reset ctl E", v, 4'b0001);
      rd_reg(4'hF, v); check("R1 reset ctl F", v, 4'b0100);
      check("R1 reset irq", irq_out, 0);
   endtask

   task automatic t_read_hold();
      logic [3:0] v;
      rd_reg(4'h0, v);
      tick1();
      check("R12 rdata holds without strobe", rdata, v);
      rd_reg(4'h0, v);
      check("R12 new read", v, 1);
   endtask

   task automatic t_sec_min();
      logic [47:0] t;
      set_time(5, 3, 7, 0, 9, 12, 58, 2);
      tick1(); read_time(t); check("R2 seconds count", t, tm(5, 3, 7, 0, 9, 12, 59));
      tick1(); read_time(t); check("R2 minute carry", t, tm(5, 3, 7, 0, 9, 13, 0));
      set_time(5, 3, 7, 0, 9, 59, 59, 2);
      tick1(); read_time(t); check("R2 hour carry", t, tm(5, 3, 7, 1, 0, 0, 0));
   endtask

   task automatic t_day24();
      logic [47:0] t; logic [3:0] v;
      set_time(99, 12, 31, 2, 3, 59, 59, 6);
      tick1(); read_time(t);
      check("R4 R6 midnight year wrap", t, tm(0, 1, 1, 0, 0, 0, 0));
      rd_reg(4'hC, v); check("R6 week wrap", v, 0);
   endtask

   task automatic t_months();
      logic [47:0] t;
      set_time(24, 2, 28, 2, 3, 59, 59, 1);
      tick1(); read_time(t); check("R6 leap Feb 29", t, tm(24, 2, 29, 0, 0, 0, 0));
      set_time(24, 2, 29, 2, 3, 59, 59, 1);
      tick1(); read_time(t); check("R6 leap Feb end", t, tm(24, 3, 1, 0, 0, 0, 0));
      set_time(23, 2, 28, 2, 3, 59, 59, 1);
      tick1(); read_time(t); check("R6 plain Feb end", t, tm(23, 3, 1, 0, 0, 0, 0));
      set_time(30, 4, 30, 2, 3, 59, 59, 1);
      tick1(); read_time(t); check("R6 30-day month", t, tm(30, 5, 1, 0, 0, 0, 0));
   endtask

   task automatic t_12h();
      logic [47:0] t; logic [3:0] v;
      wr_reg(4'hF, 4'b0000);
      set_time(10, 6, 5, 1, 1, 59, 59, 2);
      tick1(); read_time(t); check("R5 11 AM to 12 PM", t, tm(10, 6, 5, 5, 2, 0, 0));
      set_time(10, 6, 5, 5, 2, 59, 59, 2);
      tick1(); read_time(t); check("R5 12 PM to 1 PM", t, tm(10, 6, 5, 4, 1, 0, 0));
      set_time(10, 6, 5, 5, 1, 59, 59, 2);
      tick1(); read_time(t); check("R5 11 PM to 12 AM", t, tm(10, 6, 6, 1, 2, 0, 0));
      rd_reg(4'hC, v); check("R5 day carry week", v, 3);
      wr_reg(4'hF, 4'b0100);
   endtask

   task automatic t_hold();
      logic [47:0] t;
      set_time(1, 1, 1, 0, 0, 0, 10, 0);
      wr_reg(4'hD, 4'b0001);
      tick1(); tick1();
      read_time(t); check("R3 frozen in hold", t, tm(1, 1, 1, 0, 0, 0, 10));
      wr_reg(4'hD, 4'b0000);
      idle();
      read_time(t); check("R3 one pending second", t, tm(1, 1, 1, 0, 0, 0, 11));
   endtask

   task automatic t_busy();
      logic [3:0] v;
      @(negedge clk); addr = 4'hD; rd_en = 1'b1; tick_1hz = 1'b1;
      @(negedge clk); rd_en = 1'b0; tick_1hz = 1'b0;
      check("R7 busy in step cycle", rdata[1], 1);
      rd_reg(4'hD, v); check("R7 busy idle", v[1], 0);
   endtask

   task automatic t_adjust();
      logic [47:0] t; logic [3:0] v;
      set_time(2, 2, 2, 0, 8, 10, 45, 1);
      wr_reg(4'hD, 4'b1000); idle();
      read_time(t); check("R8 round up", t, tm(2, 2, 2, 0, 8, 11, 0));
      rd_reg(4'hD, v); check("R8 self clear", v[3], 0);
      set_time(2, 2, 2, 0, 8, 10, 12, 1);
      wr_reg(4'hD, 4'b1000); idle();
      read_time(t); check("R8 round down", t, tm(2, 2, 2, 0, 8, 10, 0));
      set_time(2, 2, 2, 0, 8, 10, 40, 1);
      wr_reg(4'hD, 4'b1001); idle();
      rd_reg(4'hD, v); check("R8 deferred by hold", {v[3], v[0]}, 2'b11);
      read_time(t); check("R8 no change in hold", t, tm(2, 2, 2, 0, 8, 10, 40));
      wr_reg(4'hD, 4'b0000); idle();
      read_time(t); check("R8 applied after hold", t, tm(2, 2, 2, 0, 8, 11, 0));
   endtask

   task automatic t_stop_zero();
      logic [47:0] t;
      set_time(3, 3, 3, 0, 3, 5, 20, 3);
      wr_reg(4'hF, 4'b0110);
      tick1(); tick1();
      wr_reg(4'hF, 4'b0100); idle();
      read_time(t); check("R9 stop discards ticks", t, tm(3, 3, 3, 0, 3, 5, 20));
      set_time(3, 3, 3, 0, 3, 5, 37, 3);
      wr_reg(4'hF, 4'b0101); idle();
      tick1();
      read_time(t); check("R9 seconds forced zero", t, tm(3, 3, 3, 0, 3, 5, 0));
      wr_reg(4'hF, 4'b0100); idle();
      read_time(t); check("R9 no step after release", t, tm(3, 3, 3, 0, 3, 5, 0));
   endtask

   task automatic t_irq_latch();
      logic [3:0] v;
      wr_reg(4'hE, 4'b0110); wr_reg(4'hD, 4'b0000);
      check("R10 cleared", irq_out, 0);
      tick1(); check("R10 second event", irq_out, 1);
      tick64(); check("R10 latched over tick64", irq_out, 1);
      wr_reg(4'hD, 4'b0000); check("R10 cleared by write", irq_out, 0);
      wr_reg(4'hE, 4'b0111);
      tick1(); check("R10 masked pin", irq_out, 0);
      rd_reg(4'hD, v); check("R10 flag set under mask", v[2], 1);
      wr_reg(4'hE, 4'b1010);
      set_time(4, 4, 4, 0, 4, 4, 58, 4);
      tick1(); check("R10 minute no event", irq_out, 0);
      tick1(); check("R10 minute event", irq_out, 1);
   endtask

   task automatic t_irq_pulse();
      wr_reg(4'hE, 4'b0100); wr_reg(4'hD, 4'b0000);
      tick1(); check("R11 pulse set", irq_out, 1);
      tick64(); check("R11 pulse cleared by tick64", irq_out, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle();
      t_reset();
      t_read_hold();
      t_sec_min();
      t_day24();
      t_months();
      t_12h();
      t_hold();
      t_busy();
      t_adjust();
      t_stop_zero();
      t_irq_latch();
      t_irq_pulse();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule